// File: doc/BRIEF.md
# GPIO Bank with Four-Way Peripheral Mux

This block controls a bank of general-purpose pins. Each pin is either driven by the bank's own output logic or handed to one of four internal peripherals. Software uses a small register port. Every per-pin control bit has three addresses: one where a 1 sets the bit, one where a 1 clears it, and one that reads the current state back. Writing 0 bits has no effect, so one pin can be changed without a read-modify-write. The peripheral choice for each pin is held in two plain read/write select words. The bank drives the pad's output value and output enable, plus its pull-up and pull-down controls. Pins can be switched to open-drain operation.

Every pad input passes through a two-flop synchronizer. It can then pass through an optional per-pin filter before it reaches the pin-data readback and the peripherals. The filter has two types. The glitch type drops pulses that last only one clock. The debounce type samples on a slow tick, whose period is set by a shared divider, and passes a new level only after two consecutive ticks agree.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset, every pin is in GPIO mode with pull-up on. Output enable, output data, pull-down, open-drain, filter enable, filter type, both select words and the divider are all zero. Pad output enables are all low.
- R2: The per-pin controls sit at word addresses 3k (write 1 to set), 3k+1 (write 1 to clear) and 3k+2 (status), with k = 0 GPIO ownership, 1 output enable, 2 output data, 3 pull-up, 4 pull-down, 5 open-drain, 6 filter enable, 7 filter type. Only the 1 bits of a write act, and the status shows the result on the next cycle.
- R3: A read of any set or clear address (3k or 3k+1) returns zero.
- R4: For a pin in GPIO mode with open-drain off, the pad output enable follows the output-enable bit and the pad output follows the output-data bit.
- R5: A pin that GPIO does not own takes its pad output and enable from peripheral p = {SEL_HI[n], SEL_LO[n]}. The codes are 0 = A, 1 = B, 2 = C, 3 = D, and the peripheral buses are indexed at p*32+n.
- R6: With open-drain on and output enabled, a GPIO pin drives low while its data bit is 0. While the data bit is 1 it releases the pad (output enable low).
- R7: The pad pull-up and pull-down outputs equal the pull-up and pull-down status bits.
- R8: Pin data (address 27) returns the synchronized pad level two clocks after a pad change, whatever the mux setting. The same level is given to the peripherals on `periph_i`.
- R9: With the filter enabled and type 0 (glitch), a pad pulse of one clock never reaches pin data, while a level held for several clocks does.
- R10: With the filter enabled and type 1 (debounce), a level reaches pin data only after two consecutive ticks sample it. A tick occurs every 2*(DIV+1) clocks, so a pulse shorter than one tick period is rejected.
- R11: The filter type is set to debounce through address 21 and back to glitch through address 22. Its state reads back at address 23.
- R12: SEL_LO (24), SEL_HI (25) and DIV (26) are plain read/write registers that read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle as a read request, else zero |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pad pull-up enables |
| pad_pd | output | 32 | Pad pull-down enables |
| periph_o | input | 128 | Peripheral output values, peripheral p pin n at p*32+n |
| periph_oe | input | 128 | Peripheral output enables, same layout |
| periph_i | output | 32 | Synchronized, optionally filtered, pin levels to the peripherals |

## Verification
Two functions meet on one pin in one cycle in two places. First, a pin stays driven as an open-drain GPIO output while its data bit is toggled; the pad enable is checked against the data bit in the same cycle. Second, pins in GPIO mode and pins handed to peripherals are driven side by side in one bank word, while the select words are rewritten. The combined pad word is judged against the expected per-pin source, and pin data is read back while a peripheral owns the pin. The filter checks time a pulse against the synchronizer and tick latency. Each pulse is either too short to pass or held long enough to pass.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants for the GPIO bank.
// Assumes word addressing. Control k uses addresses 3k, 3k+1 and 3k+2.
package gpio_bank_pkg;
    localparam int ADDR_W = 5;
    localparam int NCTL   = 8;

    // Control indices in the set/clear/status array
    localparam int CTL_GEN   = 0;
    localparam int CTL_OE    = 1;
    localparam int CTL_DO    = 2;
    localparam int CTL_PU    = 3;
    localparam int CTL_PD    = 4;
    localparam int CTL_MD    = 5;
    localparam int CTL_FEN   = 6;
    localparam int CTL_FTYPE = 7;

    localparam logic [ADDR_W-1:0] A_SEL_LO = 5'd24;
    localparam logic [ADDR_W-1:0] A_SEL_HI = 5'd25;
    localparam logic [ADDR_W-1:0] A_DIV    = 5'd26;
    localparam logic [ADDR_W-1:0] A_PIN    = 5'd27;
endpackage

// File: rtl/gpio_setclr_reg.sv
// Module: a per-pin control word with a set address and a clear address.
// Assumes that the set and clear addresses differ. A 1 bit acts and a 0 bit is ignored.
module gpio_setclr_reg #(
    parameter int                  NPIN     = 32,
    parameter int                  AW       = 5,
    parameter logic [AW-1:0]       SET_ADDR = '0,
    parameter logic [AW-1:0]       CLR_ADDR = '1,
    parameter logic [NPIN-1:0]     RST_VAL  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NPIN-1:0] wr_data,
    output logic [NPIN-1:0] q
);
    // Apply a set or clear mask on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (wr_en && wr_addr == SET_ADDR)
            q <= q | wr_data;
        else if (wr_en && wr_addr == CLR_ADDR)
            q <= q & ~wr_data;
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Module: register file of the bank. It holds the set/clear controls, the select words
// and the divider, and drives the read mux.
// Assumes NPIN >= DIV_W, so the divider fits in one read word.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NPIN-1:0]   req_wdata,
    input  logic [NPIN-1:0]   pin_level,
    output logic [NPIN-1:0]   rsp_rdata,
    output logic [NPIN-1:0]   ctl_q [NCTL],
    output logic [NPIN-1:0]   sel_lo_q,
    output logic [NPIN-1:0]   sel_hi_q,
    output logic [DIV_W-1:0]  div_q
);
    logic wr_en;
    assign wr_en = req_valid && req_write;

    // One set/clear register per control, at addresses 3k and 3k+1
    for (genvar k = 0; k < NCTL; k++) begin : g_ctl
        localparam logic [NPIN-1:0] RV =
            (k == CTL_GEN || k == CTL_PU) ? {NPIN{1'b1}} : '0;
        gpio_setclr_reg #(
            .NPIN(NPIN), .AW(ADDR_W),
            .SET_ADDR(ADDR_W'(3 * k)), .CLR_ADDR(ADDR_W'(3 * k + 1)),
            .RST_VAL(RV)
        ) u_ctl (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
            .wr_addr(req_addr), .wr_data(req_wdata), .q(ctl_q[k])
        );
    end

    // Plain read/write select words and divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            div_q    <= '0;
        end else if (wr_en) begin
            if (req_addr == A_SEL_LO) sel_lo_q <= req_wdata;
            if (req_addr == A_SEL_HI) sel_hi_q <= req_wdata;
            if (req_addr == A_DIV)    div_q    <= req_wdata[DIV_W-1:0];
        end
    end

    // Read mux: status words, selects, divider and pin data. Everything else reads zero
    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write) begin
            for (int k = 0; k < NCTL; k++)
                if (req_addr == ADDR_W'(3 * k + 2)) rsp_rdata = ctl_q[k];
            if (req_addr == A_SEL_LO) rsp_rdata = sel_lo_q;
            if (req_addr == A_SEL_HI) rsp_rdata = sel_hi_q;
            if (req_addr == A_DIV)    rsp_rdata = NPIN'(div_q);
            if (req_addr == A_PIN)    rsp_rdata = pin_level;
        end
    end
endmodule

// File: rtl/gpio_in_filter.sv
// Module: input path. It synchronizes the pads, runs the shared debounce tick and the
// per-pin glitch or debounce filter.
// Assumes that the pad inputs are asynchronous. The filter state runs all the time, so
// turning the filter on takes effect at once.
module gpio_in_filter #(
    parameter int NPIN  = 32,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  pad_i,
    input  logic [NPIN-1:0]  fen,
    input  logic [NPIN-1:0]  ftype,
    input  logic [DIV_W-1:0] div,
    output logic [NPIN-1:0]  pin_level
);
    localparam int CNT_W = DIV_W + 1;

    logic [NPIN-1:0]  sync1, sync2;
    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] tick_lim;
    logic             tick;

    // Two-flop synchronizer on every pad
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= pad_i;
            sync2 <= sync1;
        end
    end

    // Shared tick every 2*(div+1) clocks
    assign tick_lim = {div, 1'b1};
    assign tick     = (tick_cnt >= tick_lim);

    always_ff @(posedge clk) begin
        if (!rst_n)    tick_cnt <= '0;
        else if (tick) tick_cnt <= '0;
        else           tick_cnt <= tick_cnt + 1'b1;
    end

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        logic last_s, filt_s, step;
        // Glitch type samples every clock; debounce type samples on the tick
        assign step = ftype[n] ? tick : 1'b1;

        // Pass a level once two successive samples agree
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                last_s <= 1'b0;
                filt_s <= 1'b0;
            end else if (step) begin
                last_s <= sync2[n];
                if (sync2[n] == last_s) filt_s <= sync2[n];
            end
        end

        assign pin_level[n] = fen[n] ? filt_s : sync2[n];
    end
endmodule

// File: rtl/gpio_pad_mux.sv
// Module: per-pin output mux between the GPIO logic (with open-drain) and four peripherals.
// Assumes that the peripheral buses are laid out as peripheral p, pin n at p*NPIN+n.
module gpio_pad_mux #(
    parameter int NPIN  = 32,
    parameter int NPER  = 4
) (
    input  logic [NPIN-1:0]      gen,
    input  logic [NPIN-1:0]      oe,
    input  logic [NPIN-1:0]      dout,
    input  logic [NPIN-1:0]      md,
    input  logic [NPIN-1:0]      sel_lo,
    input  logic [NPIN-1:0]      sel_hi,
    input  logic [NPER*NPIN-1:0] periph_o,
    input  logic [NPER*NPIN-1:0] periph_oe,
    output logic [NPIN-1:0]      pad_o,
    output logic [NPIN-1:0]      pad_oe
);
    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        logic [1:0] psel;
        logic       g_o, g_oe;
        assign psel = {sel_hi[n], sel_lo[n]};

        // GPIO drive: open-drain releases the pad for a 1
        always_comb begin
            g_o  = md[n] ? 1'b0 : dout[n];
            g_oe = oe[n] && !(md[n] && dout[n]);
        end

        // Choose between GPIO and the selected peripheral
        always_comb begin
            if (gen[n]) begin
                pad_o[n]  = g_o;
                pad_oe[n] = g_oe;
            end else begin
                pad_o[n]  = periph_o[32'(psel) * NPIN + n];
                pad_oe[n] = periph_oe[32'(psel) * NPIN + n];
            end
        end
    end
endmodule

// File: rtl/gpio_mux_bank.sv
// Module: top of the GPIO bank. It joins the register file, the input filter and the pad mux.
// Assumes a single-cycle register port with reads returned in the same cycle.
module gpio_mux_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [NPIN-1:0]     req_wdata,
    output logic [NPIN-1:0]     rsp_rdata,
    input  logic [NPIN-1:0]     pad_i,
    output logic [NPIN-1:0]     pad_o,
    output logic [NPIN-1:0]     pad_oe,
    output logic [NPIN-1:0]     pad_pu,
    output logic [NPIN-1:0]     pad_pd,
    input  logic [4*NPIN-1:0]   periph_o,
    input  logic [4*NPIN-1:0]   periph_oe,
    output logic [NPIN-1:0]     periph_i
);
    logic [NPIN-1:0]  ctl_q [NCTL];
    logic [NPIN-1:0]  sel_lo_q, sel_hi_q, pin_level;
    logic [NPIN-1:0]  gen_q, oe_q, do_q, md_q;
    logic [DIV_W-1:0] div_q;

    assign gen_q = ctl_q[CTL_GEN];
    assign oe_q  = ctl_q[CTL_OE];
    assign do_q  = ctl_q[CTL_DO];
    assign md_q  = ctl_q[CTL_MD];

    gpio_bank_regs #(.NPIN(NPIN), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .pin_level(pin_level), .rsp_rdata(rsp_rdata),
        .ctl_q(ctl_q), .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q), .div_q(div_q)
    );

    gpio_in_filter #(.NPIN(NPIN), .DIV_W(DIV_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_i),
        .fen(ctl_q[CTL_FEN]), .ftype(ctl_q[CTL_FTYPE]), .div(div_q),
        .pin_level(pin_level)
    );

    gpio_pad_mux #(.NPIN(NPIN), .NPER(4)) u_mux (
        .gen(gen_q), .oe(oe_q), .dout(do_q), .md(md_q),
        .sel_lo(sel_lo_q), .sel_hi(sel_hi_q),
        .periph_o(periph_o), .periph_oe(periph_oe),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    assign pad_pu   = ctl_q[CTL_PU];
    assign pad_pd   = ctl_q[CTL_PD];
    assign periph_i = pin_level;
endmodule

// File: rtl/gpio_mux_bank_chk.sv
// Module: assertion checker for the GPIO bank, attached to the top through bind.
// Assumes the default address layout of the package.
module gpio_mux_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [NPIN-1:0]   req_wdata,
    input logic [NPIN-1:0]   rsp_rdata,
    input logic [NPIN-1:0]   gen_q,
    input logic [NPIN-1:0]   oe_q,
    input logic [NPIN-1:0]   do_q,
    input logic [NPIN-1:0]   md_q,
    input logic [NPIN-1:0]   sel_lo_q,
    input logic [NPIN-1:0]   pad_o,
    input logic [NPIN-1:0]   pad_oe
);
    AST_OE_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 5'd3) |=>
        ((oe_q & $past(req_wdata)) == $past(req_wdata)));   // R2
    AST_GEN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 5'd1) |=>
        ((gen_q & $past(req_wdata)) == '0));                 // R2
    AST_SET_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 5'd6) |-> (rsp_rdata == '0)); // R3
    AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen_q & md_q & pad_oe & pad_o) == '0));            // R6
    AST_SEL_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == A_SEL_LO) |=>
        (sel_lo_q == $past(req_wdata)));                     // R12
    AST_DO_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |=> $stable(do_q));                     // R2
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(.NPIN(NPIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .gen_q(gen_q), .oe_q(oe_q), .do_q(do_q), .md_q(md_q),
    .sel_lo_q(sel_lo_q), .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: tb/gpio_mux_bank_bench.sv
// Bench: directed scenarios for the GPIO bank, one task each, with its own counters.
module gpio_mux_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rsp_rdata;
    logic [31:0]  pad_i = '0;
    logic [31:0]  pad_o, pad_oe, pad_pu, pad_pd, periph_i;
    logic [127:0] periph_o = '0, periph_oe = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mux_bank u_gpio_mux_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .periph_o(periph_o), .periph_oe(periph_oe),
        .periph_i(periph_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'd2, v);  check("R1 gpio ownership", v, 32'hFFFF_FFFF);
        rd(5'd11, v); check("R1 pull-up", v, 32'hFFFF_FFFF);
        rd(5'd5, v);  check("R1 output enable", v, 32'h0);
        rd(5'd24, v); check("R1 sel_lo", v, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
    endtask

    task automatic t_setclr;
        logic [31:0] v;
        wr(5'd3, 32'h0000_00F0);
        wr(5'd3, 32'h0000_0001);
        rd(5'd5, v); check("R2 set accumulates", v, 32'h0000_00F1);
        wr(5'd4, 32'h0000_0010);
        rd(5'd5, v); check("R2 clear one bit", v, 32'h0000_00E1);
        wr(5'd3, 32'h0);
        rd(5'd5, v); check("R2 zero bits no effect", v, 32'h0000_00E1);
        rd(5'd3, v); check("R3 set address reads zero", v, 32'h0);
        rd(5'd4, v); check("R3 clear address reads zero", v, 32'h0);
        wr(5'd4, 32'hFFFF_FFFF);
    endtask

    task automatic t_gpio_out;
        logic [31:0] v;
        wr(5'd6, 32'h0000_00A5);
        wr(5'd3, 32'h0000_00FF);
        check("R4 pad_oe", pad_oe, 32'h0000_00FF);
        check("R4 pad_o", pad_o[7:0], 32'hA5);
        wr(5'd7, 32'h0000_0005);
        check("R4 pad_o after clear", pad_o[7:0], 32'hA0);
        rd(5'd8, v); check("R2 data status", v, 32'h0000_00A0);
    endtask

    task automatic t_mux;
        logic [31:0] v;
        // Peripheral p drives only its own pin p
        for (int p = 0; p < 4; p++) begin
            periph_o[p*32 + p]  = 1'b1;
            periph_oe[p*32 + p] = 1'b1;
        end
        wr(5'd1, 32'h0000_000F);
        wr(5'd24, 32'h0000_000A);
        wr(5'd25, 32'h0000_000C);
        check("R5 pins 0-3 to A-D with GPIO pins 4-7", pad_o[7:0], 32'hAF);
        check("R5 output enables follow peripherals", pad_oe[7:0], 32'hFF);
        rd(5'd25, v); check("R12 sel_hi readback", v, 32'h0000_000C);
        wr(5'd24, 32'h0);
        wr(5'd25, 32'h0);
        check("R5 all pins to peripheral A", pad_o[3:0], 32'h1);
        wr(5'd0, 32'h0000_000F);
    endtask

    task automatic t_open_drain;
        wr(5'd3, 32'h0000_0100);
        wr(5'd6, 32'h0000_0100);
        wr(5'd15, 32'h0000_0100);
        check("R6 open-drain releases on 1", pad_oe[8], 1'b0);
        wr(5'd7, 32'h0000_0100);
        check("R6 open-drain drives on 0", {pad_oe[8], pad_o[8]}, 2'b10);
    endtask

    task automatic t_pulls;
        wr(5'd12, 32'h0000_0003);
        wr(5'd10, 32'h0000_0001);
        check("R7 pull-up pads", pad_pu[1:0], 2'b10);
        check("R7 pull-down pads", pad_pd[1:0], 2'b11);
    endtask

    task automatic t_pin_data;
        logic [31:0] v;
        wr(5'd1, 32'h0000_0001);            // pin 0 to a peripheral
        @(negedge clk);
        pad_i = 32'h5A5A_0001;
        wait_cyc(1);
        rd(5'd27, v); check("R8 not yet after one clock", v, 32'h0);
        wait_cyc(1);
        rd(5'd27, v); check("R8 level after two clocks", v, 32'h5A5A_0001);
        check("R8 peripheral input", periph_i, 32'h5A5A_0001);
        pad_i = 32'h0;
        wait_cyc(3);
    endtask

    task automatic t_glitch;
        logic [31:0] v;
        wr(5'd18, 32'h0001_0000);
        @(negedge clk); pad_i[16] = 1'b1;
        wait_cyc(1);    pad_i[16] = 1'b0;
        wait_cyc(6);
        rd(5'd27, v); check("R9 one-clock pulse dropped", v[16], 1'b0);
        pad_i[16] = 1'b1;
        wait_cyc(6);
        rd(5'd27, v); check("R9 held level passes", v[16], 1'b1);
    endtask

    task automatic t_debounce;
        logic [31:0] v;
        wr(5'd26, 32'd3);                    // tick every 8 clocks
        rd(5'd26, v); check("R12 divider readback", v, 32'd3);
        wr(5'd21, 32'h0002_0000);
        wr(5'd18, 32'h0002_0000);
        rd(5'd23, v); check("R11 debounce selected", v, 32'h0002_0000);
        @(negedge clk); pad_i[17] = 1'b1;
        wait_cyc(5);    pad_i[17] = 1'b0;
        wait_cyc(40);
        rd(5'd27, v); check("R10 short pulse rejected", v[17], 1'b0);
        pad_i[17] = 1'b1;
        wait_cyc(4);
        rd(5'd27, v); check("R10 not passed early", v[17], 1'b0);
        wait_cyc(36);
        rd(5'd27, v); check("R10 stable level passes", v[17], 1'b1);
        wr(5'd22, 32'h0002_0000);
        rd(5'd23, v); check("R11 glitch selected again", v, 32'h0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_setclr();
        t_gpio_out();
        t_mux();
        t_open_drain();
        t_pulls();
        t_pin_data();
        t_glitch();
        t_debounce();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule